// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Slave

This block is a slave on a two-wire serial bus, placed in front of a 512-byte register array that stands in for non-volatile memory. The SCL and SDA lines arrive already synchronized to the system clock. The block pulls SDA low through a single open-drain enable. It recognizes start and stop conditions and decodes a device byte. That byte carries a fixed identifier, two strap-selected bits, an address-extension bit and a read/write flag. The block supports byte and page writes and three kinds of read: current-address, random and sequential.

Written bytes are collected in a page buffer and are committed to the array when the stop condition arrives. A busy period of a parameterized length in clock cycles follows. During that period the slave does not respond at all, so a master can poll with start plus device byte until it sees an acknowledge. The bus carries no valid/ready stream. Its only form of back-pressure is this silent busy window. The address pointer survives everything except reset, and reset clears it to zero. The array contents are not cleared by reset.

Top module: `eeprom_twi_slave`

## Requirements
- R1: A device byte is accepted only if bits 7..4 are 1010 and bits 3..2 equal `dev_sel[1:0]`. Bit 1 is the address-extension bit and bit 0 is read (1) or write (0). A non-matching byte gets no acknowledge, and the slave stays idle until the next start.
- R2: A start is SDA falling while SCL is high, and it begins reception of a new device byte. A stop is SDA rising while SCL is high, and it returns the slave to idle.
- R3: The slave pulls SDA low during the ninth clock after each accepted device byte, word-address byte and write-data byte.
- R4: For a write, the address-extension bit becomes address bit 8 and the word-address byte becomes bits 7..0. Data bytes reach the array only when the stop arrives.
- R5: In a page write, only address bits 3..0 advance after each data byte. Bytes past 16 wrap around and replace earlier bytes of the same 16-byte page.
- R6: For `WR_CYCLES` clock cycles after a stop that ends a write with data, the slave ignores start conditions and acknowledges nothing. After that period it acknowledges normally.
- R7: A current-address read returns the byte at the last accessed address plus one.
- R8: In a sequential read, each master acknowledge advances the full 9-bit pointer. The pointer wraps from 0x1FF to 0x000.
- R9: After a master not-acknowledge, the slave drives no further data and waits for a stop or a start.
- R10: After reset, `sda_oe` is 0 and the address pointer is 0, so a current-address read returns location 0.
- R11: `sda_oe` changes only while SCL is low. Read data bits are presented after SCL falling edges, most significant bit first.
- R12: A write that carries a word address but no data, ended by a stop, starts no busy period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset; clears pointer and bus state |
| scl_i | input | 1 | Synchronized serial clock line |
| sda_i | input | 1 | Synchronized serial data line level |
| dev_sel | input | 2 | Strap value matched against device byte bits 3..2 |
| sda_oe | output | 1 | 1 pulls SDA low (open drain) |

## Verification
The bench covers several corner cases:
- It writes 18 bytes into one page. A pointer that carried into bit 4 would corrupt the next page, and the read-back of the first page would then show the original first bytes instead of the two extra ones.
- It reads across 0x1FF. A design that wrapped sequential reads by page would return location 0x1F0 instead of 0x000.
- It polls immediately after a committing stop, which catches a slave that acknowledges while busy. It also polls right after an address-only write, which catches a slave that wrongly starts a busy period.
- It clocks the bus after a master not-acknowledge, which exposes a slave that keeps driving data.
- It pulses reset between transactions, which exposes a pointer that is not cleared.
- It sends wrong identifiers and wrong strap bits. A design that failed here would acknowledge a foreign device byte.

// File: rtl/twi_pkg.sv
package twi_pkg;
  localparam int ADDR_W = 9;
  localparam logic [3:0] DEV_ID = 4'b1010;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DEV,
    ST_ADDR,
    ST_WDATA,
    ST_ACK,
    ST_RDATA,
    ST_RACK,
    ST_WAIT
  } twi_st_e;
endpackage

// File: rtl/twi_bus_cond.sv
module twi_bus_cond (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic start_c,
  output logic stop_c,
  output logic scl_rise,
  output logic scl_fall
);
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
    end
  end

  assign start_c  = scl_q & scl_i & sda_q & ~sda_i;
  assign stop_c   = scl_q & scl_i & ~sda_q & sda_i;
  assign scl_rise = ~scl_q & scl_i;
  assign scl_fall = scl_q & ~scl_i;
endmodule

// File: rtl/twi_page_buf.sv
module twi_page_buf #(
  parameter int PAGE_W = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         clr,
  input  logic                         wr_en,
  input  logic [PAGE_W-1:0]            wr_idx,
  input  logic [7:0]                   wr_data,
  output logic [(1<<PAGE_W)*8-1:0]     data,
  output logic [(1<<PAGE_W)-1:0]       vld
);
  localparam int PAGE = 1 << PAGE_W;

  for (genvar g = 0; g < PAGE; g++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        data[g*8 +: 8] <= '0;
        vld[g]         <= 1'b0;
      end else if (clr) begin
        vld[g] <= 1'b0;
      end else if (wr_en && wr_idx == PAGE_W'(g)) begin
        data[g*8 +: 8] <= wr_data;
        vld[g]         <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/twi_array.sv
module twi_array #(
  parameter int ADDR_W = 9,
  parameter int PAGE_W = 4
) (
  input  logic                       clk,
  input  logic                       commit,
  input  logic [ADDR_W-PAGE_W-1:0]   page_base,
  input  logic [(1<<PAGE_W)*8-1:0]   page_data,
  input  logic [(1<<PAGE_W)-1:0]     page_vld,
  input  logic [ADDR_W-1:0]          rd_addr,
  output logic [7:0]                 rd_data
);
  localparam int PAGE  = 1 << PAGE_W;
  localparam int DEPTH = 1 << ADDR_W;

  logic [7:0] mem [DEPTH];

  for (genvar g = 0; g < PAGE; g++) begin : g_cell
    always_ff @(posedge clk) begin
      if (commit && page_vld[g])
        mem[{page_base, PAGE_W'(g)}] <= page_data[g*8 +: 8];
    end
  end

  assign rd_data = mem[rd_addr];
endmodule

// File: rtl/eeprom_twi_slave.sv
module eeprom_twi_slave
  import twi_pkg::*;
#(
  parameter int PAGE_W    = 4,
  parameter int WR_CYCLES = 50000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic [1:0] dev_sel,
  output logic       sda_oe
);
  localparam int PAGE  = 1 << PAGE_W;
  localparam int CNT_W = $clog2(WR_CYCLES + 1);

  logic start_c, stop_c, scl_rise, scl_fall;
  twi_st_e state, ack_nxt;
  logic [3:0] bit_cnt;
  logic [7:0] shreg, rd_data;
  logic [ADDR_W-1:0] ptr;
  logic blk, have_data, busy;
  logic [CNT_W-1:0] busy_cnt;
  logic wr_byte, rd_load, commit, buf_clr;
  logic [PAGE*8-1:0] pg_data;
  logic [PAGE-1:0] pg_vld;

  twi_bus_cond u_cond (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .start_c(start_c), .stop_c(stop_c), .scl_rise(scl_rise), .scl_fall(scl_fall)
  );

  assign wr_byte = !busy && state == ST_WDATA && scl_fall && bit_cnt == 4'd8;
  assign rd_load = !busy && state == ST_ACK && scl_fall && ack_nxt == ST_RDATA;
  assign commit  = !busy && stop_c && have_data;
  assign buf_clr = !busy && start_c;

  twi_page_buf #(.PAGE_W(PAGE_W)) u_pbuf (
    .clk(clk), .rst_n(rst_n), .clr(buf_clr), .wr_en(wr_byte),
    .wr_idx(ptr[PAGE_W-1:0]), .wr_data(shreg), .data(pg_data), .vld(pg_vld)
  );

  twi_array #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_array (
    .clk(clk), .commit(commit), .page_base(ptr[ADDR_W-1:PAGE_W]),
    .page_data(pg_data), .page_vld(pg_vld), .rd_addr(ptr), .rd_data(rd_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      ack_nxt   <= ST_IDLE;
      bit_cnt   <= '0;
      shreg     <= '0;
      ptr       <= '0;
      blk       <= 1'b0;
      have_data <= 1'b0;
      busy      <= 1'b0;
      busy_cnt  <= '0;
      sda_oe    <= 1'b0;
    end else if (busy) begin
      state    <= ST_IDLE;
      busy_cnt <= busy_cnt - 1'b1;
      if (busy_cnt == CNT_W'(1)) busy <= 1'b0;
    end else if (start_c) begin
      state     <= ST_DEV;
      bit_cnt   <= '0;
      sda_oe    <= 1'b0;
      have_data <= 1'b0;
    end else if (stop_c) begin
      state     <= ST_IDLE;
      sda_oe    <= 1'b0;
      have_data <= 1'b0;
      if (have_data) begin
        busy     <= 1'b1;
        busy_cnt <= CNT_W'(WR_CYCLES);
      end
    end else begin
      case (state)
        ST_DEV, ST_ADDR, ST_WDATA: begin
          if (scl_rise && bit_cnt != 4'd8) begin
            shreg   <= {shreg[6:0], sda_i};
            bit_cnt <= bit_cnt + 4'd1;
          end else if (scl_fall && bit_cnt == 4'd8) begin
            bit_cnt <= '0;
            if (state == ST_DEV) begin
              if (shreg[7:4] == DEV_ID && shreg[3:2] == dev_sel) begin
                sda_oe <= 1'b1;
                state  <= ST_ACK;
                if (shreg[0]) begin
                  ack_nxt <= ST_RDATA;
                end else begin
                  ack_nxt <= ST_ADDR;
                  blk     <= shreg[1];
                end
              end else begin
                state <= ST_IDLE;
              end
            end else if (state == ST_ADDR) begin
              ptr     <= {blk, shreg};
              sda_oe  <= 1'b1;
              state   <= ST_ACK;
              ack_nxt <= ST_WDATA;
            end else begin
              ptr[PAGE_W-1:0] <= ptr[PAGE_W-1:0] + PAGE_W'(1);
              have_data       <= 1'b1;
              sda_oe          <= 1'b1;
              state           <= ST_ACK;
              ack_nxt         <= ST_WDATA;
            end
          end
        end
        ST_ACK: begin
          if (scl_fall) begin
            state <= ack_nxt;
            if (ack_nxt == ST_RDATA) begin
              shreg   <= rd_data;
              sda_oe  <= ~rd_data[7];
              ptr     <= ptr + ADDR_W'(1);
              bit_cnt <= '0;
            end else begin
              sda_oe <= 1'b0;
            end
          end
        end
        ST_RDATA: begin
          if (scl_fall) begin
            if (bit_cnt == 4'd7) begin
              sda_oe  <= 1'b0;
              bit_cnt <= '0;
              state   <= ST_RACK;
            end else begin
              shreg   <= {shreg[6:0], 1'b0};
              sda_oe  <= ~shreg[6];
              bit_cnt <= bit_cnt + 4'd1;
            end
          end
        end
        ST_RACK: begin
          if (scl_rise) begin
            if (sda_i) begin
              state <= ST_WAIT;
            end else begin
              state   <= ST_ACK;
              ack_nxt <= ST_RDATA;
            end
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/twi_checker.sv
module twi_checker
  import twi_pkg::*;
#(
  parameter int PAGE_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              scl_i,
  input logic              sda_oe,
  input logic              start_c,
  input logic              stop_c,
  input logic              busy,
  input logic              wr_byte,
  input logic              rd_load,
  input logic [ADDR_W-1:0] ptr,
  input twi_st_e           state
);
  AST_OE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> !scl_i); // R11
  AST_BUSY_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !sda_oe); // R6
  AST_BUSY_NO_START: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start_c) |=> state == ST_IDLE); // R6
  AST_STOP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    stop_c |=> state == ST_IDLE); // R2
  AST_START_DEV: assert property (@(posedge clk) disable iff (!rst_n)
    (start_c && !busy) |=> state == ST_DEV); // R2
  AST_PAGE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    wr_byte |=> $stable(ptr[ADDR_W-1:PAGE_W])); // R5
  AST_SEQ_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    rd_load |=> ptr == ADDR_W'($past(ptr) + 1'b1)); // R8
endmodule

bind eeprom_twi_slave twi_checker #(.PAGE_W(PAGE_W)) u_twi_checker (
  .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_oe(sda_oe),
  .start_c(start_c), .stop_c(stop_c), .busy(busy), .wr_byte(wr_byte),
  .rd_load(rd_load), .ptr(ptr), .state(state)
);

// File: tb/test_eeprom_twi_slave.sv
`timescale 1ns/1ps
module test_eeprom_twi_slave;
  localparam int WRC = 300;
  localparam logic [1:0] SEL = 2'b10;

  logic clk = 1'b0, rst_n = 1'b0, scl = 1'b1, m_low = 1'b0;
  logic sda_oe;
  wire  sda = ~(m_low | sda_oe);
  int checks = 0, errors = 0, hi_glitch = 0;
  logic [7:0] wbuf [32];
  logic [7:0] rbuf [32];

  always #2.5 clk = ~clk;

  eeprom_twi_slave #(.PAGE_W(4), .WR_CYCLES(WRC)) i_eeprom_twi_slave (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda), .dev_sel(SEL), .sda_oe(sda_oe)
  );

  task automatic tick(input int n); repeat (n) @(negedge clk); endtask

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic m_start;
    m_low = 1'b0; tick(4); scl = 1'b1; tick(4); m_low = 1'b1; tick(4); scl = 1'b0; tick(4);
  endtask

  task automatic m_stop;
    scl = 1'b0; m_low = 1'b1; tick(4); scl = 1'b1; tick(4); m_low = 1'b0; tick(4);
  endtask

  task automatic m_send(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      m_low = ~b[i]; tick(4); scl = 1'b1; tick(4); scl = 1'b0; tick(1);
    end
    m_low = 1'b0; tick(4); scl = 1'b1; tick(2); ack = ~sda; tick(2); scl = 1'b0; tick(1);
  endtask

  task automatic m_recv(input logic give_ack, output logic [7:0] b);
    logic s0;
    m_low = 1'b0;
    for (int i = 7; i >= 0; i--) begin
      tick(4); scl = 1'b1; tick(1); s0 = sda; tick(2); b[i] = sda;
      if (s0 !== b[i]) hi_glitch++;
      tick(1); scl = 1'b0; tick(1);
    end
    m_low = give_ack; tick(4); scl = 1'b1; tick(4); scl = 1'b0; tick(1); m_low = 1'b0;
  endtask

  function automatic logic [7:0] dev(input logic [8:0] a, input logic rd);
    return {4'b1010, SEL, a[8], rd};
  endfunction

  task automatic do_write(input string req, input logic [8:0] a, input int n);
    logic ack;
    m_start;
    m_send(dev(a, 1'b0), ack); chk({req, " dev ack"}, 8'(ack), 8'h01);
    m_send(a[7:0], ack);       chk({req, " addr ack R3"}, 8'(ack), 8'h01);
    for (int i = 0; i < n; i++) begin
      m_send(wbuf[i], ack);    chk({req, " data ack R3"}, 8'(ack), 8'h01);
    end
    m_stop;
  endtask

  task automatic do_read(input string req, input logic [8:0] a, input int n);
    logic ack;
    m_start;
    m_send(dev(a, 1'b0), ack);
    m_send(a[7:0], ack);
    m_start;
    m_send(dev(a, 1'b1), ack); chk({req, " read dev ack"}, 8'(ack), 8'h01);
    for (int i = 0; i < n; i++) m_recv(i != n - 1, rbuf[i]);
    m_stop;
  endtask

  task automatic t_reset;
    chk("R10 sda_oe after reset", 8'(sda_oe), 8'h00);
    chk("R10 sda idle", 8'(sda), 8'h01);
  endtask

  task automatic t_bad_dev;
    logic ack;
    m_start; m_send({4'b1010, ~SEL, 2'b00}, ack); chk("R1 wrong strap nack", 8'(ack), 8'h00);
    m_send(dev(9'h0, 1'b0), ack); chk("R1 idle until start", 8'(ack), 8'h00);
    m_stop;
    m_start; m_send({4'b0110, SEL, 2'b00}, ack); chk("R1 wrong id nack", 8'(ack), 8'h00);
    m_start; m_send(dev(9'h0, 1'b0), ack); chk("R2 repeated start accepted", 8'(ack), 8'h01);
    m_stop;
  endtask

  task automatic t_byte_block;
    wbuf[0] = 8'hA5; do_write("R4 low", 9'h005, 1); tick(WRC + 20);
    wbuf[0] = 8'h3C; do_write("R4 high", 9'h105, 1); tick(WRC + 20);
    do_read("R4", 9'h105, 1); chk("R4 block bit high read", rbuf[0], 8'h3C);
    do_read("R4", 9'h005, 1); chk("R4 block bit low read", rbuf[0], 8'hA5);
  endtask

  task automatic t_busy;
    logic ack;
    wbuf[0] = 8'h11; do_write("R6", 9'h020, 1);
    m_start; m_send(dev(9'h0, 1'b0), ack); chk("R6 nack while busy", 8'(ack), 8'h00);
    m_stop;
    tick(WRC + 20);
    m_start; m_send(dev(9'h0, 1'b0), ack); chk("R6 ack after busy", 8'(ack), 8'h01);
    m_stop;
    do_read("R6", 9'h020, 1); chk("R6 data committed", rbuf[0], 8'h11);
  endtask

  task automatic t_page;
    for (int i = 0; i < 18; i++) wbuf[i] = 8'hC0 + 8'(i);
    do_write("R5", 9'h030, 18); tick(WRC + 20);
    do_read("R5", 9'h030, 16);
    for (int i = 0; i < 16; i++)
      chk("R5 page wrap", rbuf[i], (i < 2) ? 8'hD0 + 8'(i) : 8'hC0 + 8'(i));
  endtask

  task automatic t_current;
    logic ack; logic [7:0] b;
    do_read("R7", 9'h030, 1); chk("R7 setup", rbuf[0], 8'hD0);
    m_start; m_send(dev(9'h0, 1'b1), ack); m_recv(1'b0, b); m_stop;
    chk("R7 current read next", b, 8'hD1);
  endtask

  task automatic t_addr_only;
    logic ack; logic [7:0] b;
    m_start; m_send(dev(9'h033, 1'b0), ack); m_send(8'h33, ack); m_stop;
    m_start; m_send(dev(9'h0, 1'b1), ack); chk("R12 no busy after address only", 8'(ack), 8'h01);
    m_recv(1'b0, b); m_stop;
    chk("R12 pointer set by address", b, 8'hC3);
  endtask

  task automatic t_wrap;
    wbuf[0] = 8'h77; do_write("R8", 9'h1FF, 1); tick(WRC + 20);
    wbuf[0] = 8'h88; do_write("R8", 9'h000, 1); tick(WRC + 20);
    do_read("R8", 9'h1FF, 2);
    chk("R8 last location", rbuf[0], 8'h77);
    chk("R8 wrap to zero", rbuf[1], 8'h88);
  endtask

  task automatic t_nack;
    logic [7:0] b;
    do_read("R9", 9'h1FF, 1);
    chk("R9 byte before nack", rbuf[0], 8'h77);
    m_start; m_send(dev(9'h0, 1'b1), b[0]); m_recv(1'b0, b);
    chk("R9 read before nack", b, 8'h88);
    m_recv(1'b1, b);
    chk("R9 no data after nack", b, 8'hFF);
    m_stop;
    chk("R11 sda stable while scl high", 8'(hi_glitch), 8'h00);
  endtask

  task automatic t_power_on;
    logic ack; logic [7:0] b;
    tick(2); rst_n = 1'b0; tick(4); rst_n = 1'b1; tick(4);
    chk("R10 sda_oe low after reset", 8'(sda_oe), 8'h00);
    m_start; m_send(dev(9'h0, 1'b1), ack); m_recv(1'b0, b); m_stop;
    chk("R10 pointer zero after reset", b, 8'h88);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    tick(5); rst_n = 1'b1; tick(5);
    t_reset;
    t_bad_dev;
    t_byte_block;
    t_busy;
    t_page;
    t_current;
    t_addr_only;
    t_wrap;
    t_nack;
    t_power_on;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule